// File: doc/BRIEF.md
# Configuration change protection unit

This block stands between the CPU and two classes of sensitive operation: writes to guarded I/O registers, and self-programming commands to the nonvolatile memory controller. Neither kind of access goes through unless software first stores a signature byte into the unit's key register. A correct signature opens a short unlock window. The window is measured in retired CPU instructions, not in clock cycles.

Each of the two signatures selects its own kind of window. The unit drives one enable per window kind, so the guarded logic can check whether it is unlocked. It also drives a hold line that keeps the interrupt controller from taking an interrupt while a window is open, and a readable status byte for the key register. Each guarded access is presented on a per-kind strobe. The unit answers every strobe with a one-cycle grant or block pulse on the following cycle. A granted access consumes the window.

Top module: `ccp_guard`

## Requirements
- R1: A key register write of 0x9D opens a self-programming window. From the next cycle, `spm_unlock` is 1 and `key_status` reads 0x02.
- R2: A key register write of 0xD8 opens an I/O-register window. From the next cycle, `io_unlock` is 1 and `key_status` reads 0x01.
- R3: A window stays open for four `insn_retired` strobes counted after the signature write, and closes in the cycle after the fourth. A strobe in the same cycle as the signature write is not counted. Cycles without a strobe do not shorten the window.
- R4: `irq_hold` is 1 exactly while a window of either kind is open. When the window closes, it drops in the same cycle that the status bits clear.
- R5: Bit 0 of `key_status` is the I/O window and bit 1 is the self-programming window. Bits 7 to 2 always read 0, and bits 1 and 0 are never both 1.
- R6: A key register write of any value other than the two signatures has no effect. A closed unit stays closed, and an open window keeps its kind and its remaining count.
- R7: An access strobe whose kind matches the open window produces a one-cycle `acc_grant` pulse on the next cycle and closes the window. This holds even when it arrives on the last counted instruction.
- R8: An access strobe that finds no window open, or a window of the other kind, produces a one-cycle `acc_block` pulse on the next cycle and leaves the window state unchanged. The strobe is judged against the window state before any signature written in the same cycle takes effect.
- R9: A valid signature written while a window is open restarts the four-instruction count and switches to the kind that the new signature selects.
- R10: While `rst_n` is low at a clock edge, every window closes and `key_status`, `irq_hold`, both unlocks and both pulses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_wr | input | 1 | CPU write strobe for the key register |
| key_wdata | input | 8 | Byte being written to the key register |
| insn_retired | input | 1 | One pulse per executed CPU instruction |
| acc_io | input | 1 | Attempted write to a guarded I/O register |
| acc_spm | input | 1 | Attempted self-programming command |
| io_unlock | output | 1 | I/O-register window open |
| spm_unlock | output | 1 | Self-programming window open |
| irq_hold | output | 1 | Suppress interrupt acceptance |
| key_status | output | 8 | Read value of the key register |
| acc_grant | output | 1 | One-cycle pulse: previous access allowed |
| acc_block | output | 1 | One-cycle pulse: previous access refused |

## Verification
A stuck or mis-decremented instruction counter shows up one cycle after the affected strobe. The status bits and `irq_hold` then either stay set past the fourth counted instruction or clear before it. A wrong window kind shows up in the next cycle as a grant where a block was due, or the reverse, and as the wrong status bit. Any state left behind after a grant or a stray write shows up at the next access strobe, because that strobe's pulse arrives on the following cycle.

// File: rtl/ccp_pkg.sv
// Shared types for the configuration change protection unit.
// Assumes: the window kind encoding doubles as status bits [1:0].
package ccp_pkg;
    typedef enum logic [1:0] {
        WIN_NONE = 2'b00,
        WIN_IO   = 2'b01,
        WIN_SPM  = 2'b10
    } win_mode_e;
endpackage

// File: rtl/ccp_sig_decode.sv
// Signature decoder: classifies a key register write as an I/O unlock,
// a self-programming unlock, or nothing.
// Assumes: key_wr is a single-cycle strobe from the CPU store path.
module ccp_sig_decode
    import ccp_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  SIG_IO  = 8'hD8,
    parameter logic [7:0]  SIG_SPM = 8'h9D
) (
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    output logic              sig_hit,
    output win_mode_e         sig_mode
);
    localparam logic [DATA_W-1:0] KEY_IO  = DATA_W'(SIG_IO);
    localparam logic [DATA_W-1:0] KEY_SPM = DATA_W'(SIG_SPM);

    // Match the written byte against both signatures.
    always_comb begin
        sig_mode = WIN_NONE;
        if (key_wr && key_wdata == KEY_IO)       sig_mode = WIN_IO;
        else if (key_wr && key_wdata == KEY_SPM) sig_mode = WIN_SPM;
        sig_hit = (sig_mode != WIN_NONE);
    end
endmodule

// File: rtl/ccp_window.sv
// Window tracker: holds the open window kind and the remaining instruction
// count. A signature loads the full count, retired instructions count it
// down, and a granted access closes the window at once.
// Assumes: a signature outranks both a close request and a retire strobe.
module ccp_window
    import ccp_pkg::*;
#(
    parameter int WINDOW_LEN = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_hit,
    input  win_mode_e sig_mode,
    input  logic      insn_retired,
    input  logic      close_req,
    output win_mode_e win_mode,
    output logic      win_open
);
    localparam int CNT_W = $clog2(WINDOW_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    // Update the window kind and the remaining instruction count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_mode <= WIN_NONE;
            remain   <= '0;
        end else if (sig_hit) begin
            win_mode <= sig_mode;
            remain   <= CNT_FULL;
        end else if (win_open && close_req) begin
            win_mode <= WIN_NONE;
            remain   <= '0;
        end else if (win_open && insn_retired) begin
            remain <= remain - CNT_ONE;
            if (remain == CNT_ONE) win_mode <= WIN_NONE;
        end
    end

    assign win_open = (win_mode != WIN_NONE);

    // Kind register and counter must agree on whether a window is open (R3).
    p_count_agrees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_mode != WIN_NONE) == (remain != '0));

    // A signature always leaves the full count and the chosen kind (R1, R2, R9).
    p_fresh_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit |=> (remain == CNT_FULL) && (win_mode == $past(sig_mode)));

    // Each counted instruction removes exactly one from the count (R3).
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && insn_retired && !sig_hit && !close_req)
        |=> remain == $past(remain) - CNT_ONE);

    // No strobe, no signature, no access: the count holds (R3).
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_retired && !sig_hit && !close_req) |=> $stable(remain));
endmodule

// File: rtl/ccp_access_check.sv
// Access checker: judges each guarded access strobe against the current
// window, requests a close on a match, and registers grant/block pulses.
// Assumes: access strobes are single-cycle and judged on pre-edge state.
module ccp_access_check
    import ccp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  win_mode_e win_mode,
    input  logic      acc_io,
    input  logic      acc_spm,
    output logic      close_req,
    output logic      acc_grant,
    output logic      acc_block
);
    logic io_ok, spm_ok, io_bad, spm_bad;

    // Split each strobe into allowed and refused against the open kind.
    always_comb begin
        io_ok     = acc_io  && (win_mode == WIN_IO);
        spm_ok    = acc_spm && (win_mode == WIN_SPM);
        io_bad    = acc_io  && !io_ok;
        spm_bad   = acc_spm && !spm_ok;
        close_req = io_ok || spm_ok;
    end

    // Register the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_grant <= 1'b0;
            acc_block <= 1'b0;
        end else begin
            acc_grant <= close_req;
            acc_block <= io_bad || spm_bad;
        end
    end

    // A lone strobe gets exactly one of the two answers (R7, R8).
    p_one_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_io ^ acc_spm) |=> (acc_grant ^ acc_block));

    // No strobe, no answer (R7, R8).
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_io && !acc_spm) |=> (!acc_grant && !acc_block));
endmodule

// File: rtl/ccp_guard.sv
// Configuration change protection unit, top level. Ties the signature
// decoder, the window tracker and the access checker together and forms
// the unlock enables, the interrupt hold and the key status byte.
// Assumes: one CPU, one key register, strobes synchronous to clk.
module ccp_guard
    import ccp_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         WINDOW_LEN = 4,
    parameter logic [7:0] SIG_IO     = 8'hD8,
    parameter logic [7:0] SIG_SPM    = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              insn_retired,
    input  logic              acc_io,
    input  logic              acc_spm,
    output logic              io_unlock,
    output logic              spm_unlock,
    output logic              irq_hold,
    output logic [DATA_W-1:0] key_status,
    output logic              acc_grant,
    output logic              acc_block
);
    localparam int PAD_W = DATA_W - 2;

    logic      sig_hit;
    win_mode_e sig_mode;
    win_mode_e win_mode;
    logic      win_open;
    logic      close_req;

    ccp_sig_decode #(
        .DATA_W (DATA_W),
        .SIG_IO (SIG_IO),
        .SIG_SPM(SIG_SPM)
    ) u_decode (
        .key_wr   (key_wr),
        .key_wdata(key_wdata),
        .sig_hit  (sig_hit),
        .sig_mode (sig_mode)
    );

    ccp_window #(
        .WINDOW_LEN(WINDOW_LEN)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_hit     (sig_hit),
        .sig_mode    (sig_mode),
        .insn_retired(insn_retired),
        .close_req   (close_req),
        .win_mode    (win_mode),
        .win_open    (win_open)
    );

    ccp_access_check u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_mode (win_mode),
        .acc_io   (acc_io),
        .acc_spm  (acc_spm),
        .close_req(close_req),
        .acc_grant(acc_grant),
        .acc_block(acc_block)
    );

    // Form the outward view of the window state.
    always_comb begin
        io_unlock  = (win_mode == WIN_IO);
        spm_unlock = (win_mode == WIN_SPM);
        irq_hold   = win_open;
        key_status = {{PAD_W{1'b0}}, win_mode};
    end

    // At most one kind of window is ever reported (R5).
    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(key_status[1:0]));

    // A rejected write with nothing else going on changes nothing (R6).
    p_bad_key_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !sig_hit && !insn_retired && !acc_io && !acc_spm)
        |=> $stable(key_status));

    // A granted access closes the window unless a signature reopens it (R7).
    p_grant_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && !sig_hit) |=> (key_status == '0) && acc_grant);

    // A blocked lone I/O access leaves the window untouched (R8).
    p_block_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_io && !io_unlock && !acc_spm && !key_wr && !insn_retired)
        |=> $stable(key_status) && acc_block);

    // A valid signature reports its own kind on the next cycle (R1, R2).
    p_opens_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit |=> irq_hold && (key_status[1:0] == $past(sig_mode)));
endmodule

// File: tb/tb_ccp_guard.sv
// Testbench: a vector table walked by one loop, then directed reset tests.
module tb_ccp_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_wr = 1'b0;
    logic [7:0] key_wdata = '0;
    logic       insn_retired = 1'b0;
    logic       acc_io = 1'b0;
    logic       acc_spm = 1'b0;
    logic       io_unlock, spm_unlock, irq_hold, acc_grant, acc_block;
    logic [7:0] key_status;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    ccp_guard dut (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
        .insn_retired(insn_retired), .acc_io(acc_io), .acc_spm(acc_spm),
        .io_unlock(io_unlock), .spm_unlock(spm_unlock), .irq_hold(irq_hold),
        .key_status(key_status), .acc_grant(acc_grant), .acc_block(acc_block)
    );

    // Row: {req[3:0], wr, data[7:0], retire, acc_io, acc_spm, status[1:0], grant, block}
    function automatic logic [19:0] mk(input int req, input bit wr, input logic [7:0] d,
                                       input bit ret, input bit aio, input bit aspm,
                                       input logic [1:0] st, input bit g, input bit b);
        return {4'(req), wr, d, ret, aio, aspm, st, g, b};
    endfunction

    localparam int NV = 32;
    localparam logic [19:0] TBL [NV] = '{
        mk(1, 1, 8'h9D, 0, 0, 0, 2'b10, 0, 0),  // R1 open self-programming
        mk(3, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),  // R3 count 1
        mk(3, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),  // R3 count 2
        mk(3, 0, 8'h00, 0, 0, 0, 2'b10, 0, 0),  // R3 idle cycle not counted
        mk(3, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),  // R3 count 3
        mk(4, 0, 8'h00, 1, 0, 0, 2'b00, 0, 0),  // R4 count 4 closes, hold drops
        mk(8, 0, 8'h00, 0, 0, 1, 2'b00, 0, 1),  // R8 no window
        mk(2, 1, 8'hD8, 0, 0, 0, 2'b01, 0, 0),  // R2 open I/O
        mk(8, 0, 8'h00, 0, 0, 1, 2'b01, 0, 1),  // R8 wrong kind, window kept
        mk(7, 0, 8'h00, 0, 1, 0, 2'b00, 1, 0),  // R7 grant closes
        mk(6, 1, 8'h55, 0, 0, 0, 2'b00, 0, 0),  // R6 stray value when closed
        mk(3, 1, 8'hD8, 1, 0, 0, 2'b01, 0, 0),  // R3 same-cycle retire ignored
        mk(3, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(3, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(3, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(7, 0, 8'h00, 1, 1, 0, 2'b00, 1, 0),  // R7 access on last instruction
        mk(2, 1, 8'hD8, 0, 0, 0, 2'b01, 0, 0),
        mk(9, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(9, 1, 8'h9D, 0, 0, 0, 2'b10, 0, 0),  // R9 switch kind, restart
        mk(9, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),
        mk(9, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),
        mk(9, 0, 8'h00, 1, 0, 0, 2'b10, 0, 0),
        mk(9, 0, 8'h00, 1, 0, 0, 2'b00, 0, 0),  // R9 full four after restart
        mk(2, 1, 8'hD8, 0, 0, 0, 2'b01, 0, 0),
        mk(6, 1, 8'h00, 0, 0, 0, 2'b01, 0, 0),  // R6 stray value, window kept
        mk(6, 1, 8'h9C, 0, 0, 0, 2'b01, 0, 0),  // R6 near-miss value
        mk(6, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(6, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(6, 0, 8'h00, 1, 0, 0, 2'b01, 0, 0),
        mk(6, 0, 8'h00, 1, 0, 0, 2'b00, 0, 0),  // R6 count was not disturbed
        mk(8, 1, 8'h9D, 0, 0, 1, 2'b10, 0, 1),  // R8 judged on old state
        mk(7, 0, 8'h00, 0, 0, 1, 2'b00, 1, 0)   // R7 self-programming grant
    };

    // Compare the full output view against an expected status/pulse pair.
    task automatic check_view(input int req, input logic [1:0] st, input bit g, input bit b);
        logic [12:0] got, exp;
        got = {key_status, irq_hold, io_unlock, spm_unlock, acc_grant, acc_block};
        exp = {6'b0, st, (st != 2'b00), st[0], st[1], g, b};   // R4 R5 layout
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_view(10, 2'b00, 0, 0);            // R10 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {key_wr, key_wdata, insn_retired, acc_io, acc_spm} = TBL[i][15:4];
            @(negedge clk);
            check_view(int'(TBL[i][19:16]), TBL[i][3:2], TBL[i][1], TBL[i][0]);
            {key_wr, key_wdata, insn_retired, acc_io, acc_spm} = '0;
        end
        // R10: reset in the middle of an open window, with a pending grant.
        key_wr = 1'b1; key_wdata = 8'hD8;
        @(negedge clk);
        key_wr = 1'b0; acc_io = 1'b1;
        @(negedge clk);
        acc_io = 1'b0; rst_n = 1'b0;
        key_wr = 1'b1; key_wdata = 8'h9D;
        @(negedge clk);
        check_view(10, 2'b00, 0, 0);            // R10 reset beats signature
        key_wr = 1'b0; rst_n = 1'b1;
        acc_spm = 1'b1;
        @(negedge clk);
        acc_spm = 1'b0;
        check_view(8, 2'b00, 0, 1);             // R8 nothing open after reset
        @(negedge clk);
        check_view(7, 2'b00, 0, 0);             // R7 pulses last one cycle
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule